// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block turns one block-transfer command of a 32-bit processor with banked registers into a stream of single-word transfers. A command carries a register mask, the index and value of a base register, and flags for direction (load or store), address direction (up or down), the address update point (before or after each word), base write-back and the bank/mode bit. The block emits one transfer per cycle. Each transfer has a word address, a register index, a bank select and a direction. When the command ends, the block reports the updated base value and raises any flags for illegal use.

The bank/mode bit has two meanings. On a load that includes the program counter (index 15), it restores the saved status word in the same cycle as the program counter load. In every other case it moves all transfers onto the user bank. Combinations that are not allowed are flagged. A one-cycle hazard stall follows any load that used the user bank. Memory, the register file and the status registers sit outside the block.

Top module: `multi_xfer_seq`

## Requirements
- R1: A command is accepted only when `start` is high while `busy` is low. Mask bits transfer one per cycle in ascending index order, starting the cycle after acceptance. Consecutive transfers are 4 bytes apart, so the lowest index always takes the lowest address.
- R2: With n set bits, the first (lowest) address depends on the mode. Up/after gives base. Up/before gives base+4. Down/after gives base-4n+4. Down/before gives base-4n. Example: down/before, base 0x1000, registers 1, 5 and 7 gives addresses 0x0FF4, 0x0FF8 and 0x0FFC.
- R3: `done` pulses for one cycle, one cycle after the last transfer. If write-back is requested and allowed, `wbValid` is high in that cycle, with `wbVal` equal to base+4n (up) or base-4n (down) and `wbIdx` equal to the base index.
- R4: On a privileged load with bit 15 and the bank/mode bit both set, `statusRestore` is high in exactly the cycle that transfers register 15. All transfers of that command use the current bank (`xferUserBank`=0).
- R5: On a privileged command with the bank/mode bit set, every transfer has `xferUserBank`=1 when the command is a store, or a load without bit 15.
- R6: If the bank/mode bit is set while `privileged` is 0, `illegalS` is high with `done`. In that case there is no status restore and no user-bank selection.
- R7: If write-back is requested on a user-bank transfer (R5), `wbConflict` is high with `done` and `wbValid` stays low.
- R8: A base index of 15 performs no transfers. `done` and `illegalBase` arrive one cycle after acceptance, with no write-back.
- R9: After a user-bank load with at least one transfer, `bankStall` is high for exactly the one cycle after `done`, and `busy` stays high in that cycle.
- R10: An empty mask performs no transfers. `done` comes one cycle after acceptance, and any write-back returns the unchanged base.
- R11: `busy` is high from the cycle after acceptance through `done` and any stall cycle. A `start` pulse while busy is ignored and does not alter the running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request |
| regList | input | 16 | Register mask, bit i selects register i |
| baseIdx | input | 4 | Base register index |
| baseVal | input | 32 | Base register value |
| isLoad | input | 1 | 1 = load, 0 = store |
| addUp | input | 1 | 1 = addresses go up, 0 = down |
| preIdx | input | 1 | 1 = update before each word, 0 = after |
| wrBack | input | 1 | Write updated base back |
| sBit | input | 1 | Bank/mode bit |
| privileged | input | 1 | Processor is in a privileged mode |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (one cycle) |
| xferValid | output | 1 | Transfer this cycle |
| xferAddr | output | 32 | Word address of the transfer |
| xferReg | output | 4 | Register index of the transfer |
| xferUserBank | output | 1 | Transfer uses the user bank |
| xferLoad | output | 1 | Transfer is a load |
| statusRestore | output | 1 | Copy saved status word to current status |
| wbValid | output | 1 | Base write-back this cycle |
| wbIdx | output | 4 | Base register index for write-back |
| wbVal | output | 32 | Updated base value |
| illegalS | output | 1 | Bank/mode bit used outside a privileged mode |
| illegalBase | output | 1 | Base index 15 rejected |
| wbConflict | output | 1 | Write-back suppressed on user-bank transfer |
| bankStall | output | 1 | Banked-register hazard stall |

## Verification
The first transfer is due one cycle after the edge that accepts `start`, and each later transfer follows one cycle after the one before. `done`, the write-back and the flags come one cycle after the last transfer, or one cycle after acceptance when there are no transfers, and `bankStall` comes one cycle after `done`. For each command the bench builds a queue of expected outputs, one entry per cycle, from the mask and flags alone. It then compares every output at the falling edge of each cycle from acceptance until the block is idle again. A stray `start` pulse is injected in the middle of one command to confirm that it is ignored.

// File: rtl/multi_xfer_pkg.sv
package multi_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_FIN,
    ST_STALL
  } seqState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;   // capture a new command
    logic step;   // retire the current register, advance address
  } dpCtl_t;

endpackage

// File: rtl/multi_xfer_dp.sv
module multi_xfer_dp
  import multi_xfer_pkg::*;
#(
  parameter int NREGS      = 16,
  parameter int XLEN       = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDXW      = $clog2(NREGS),
  localparam int CNTW      = $clog2(NREGS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [NREGS-1:0] regList,
  input  logic [XLEN-1:0]  baseVal,
  input  logic             addUp,
  input  logic             preIdx,
  output logic [IDXW-1:0]  curReg,
  output logic [XLEN-1:0]  curAddr,
  output logic [XLEN-1:0]  wbVal,
  output logic             lastOne
);

  logic [NREGS-1:0] remList;
  logic [NREGS-1:0] lowBit;
  logic [NREGS-1:0] remNext;
  logic [CNTW-1:0]  regCnt;
  logic [XLEN-1:0]  span;
  logic [XLEN-1:0]  startAddr;
  logic [XLEN-1:0]  wbNext;
  logic [XLEN-1:0]  addrReg;
  logic [XLEN-1:0]  wbReg;

  localparam logic [XLEN-1:0] STEP_B = XLEN'(WORD_BYTES);

  // population count of the incoming mask
  always_comb begin
    regCnt = '0;
    for (int i = 0; i < NREGS; i++) regCnt = regCnt + CNTW'(regList[i]);
  end

  always_comb begin
    span = XLEN'(regCnt) * STEP_B;
    if (addUp) begin
      startAddr = preIdx ? baseVal + STEP_B : baseVal;
      wbNext    = baseVal + span;
    end else begin
      startAddr = preIdx ? baseVal - span : baseVal - span + STEP_B;
      wbNext    = baseVal - span;
    end
  end

  // lowest remaining register
  always_comb begin
    curReg = '0;
    for (int i = NREGS - 1; i >= 0; i--) begin
      if (remList[i]) curReg = IDXW'(i);
    end
  end

  assign lowBit  = remList & (~remList + NREGS'(1));
  assign remNext = remList & ~lowBit;
  assign lastOne = (remNext == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remList <= '0;
      addrReg <= '0;
      wbReg   <= '0;
    end else if (ctl.load) begin
      remList <= regList;
      addrReg <= startAddr;
      wbReg   <= wbNext;
    end else if (ctl.step) begin
      remList <= remNext;
      addrReg <= addrReg + STEP_B;
    end
  end

  assign curAddr = addrReg;
  assign wbVal   = wbReg;

  // R1
  step_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> (remList != '0));

  // R1
  step_shrinks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.load) |=> ($countones(remList) == $countones($past(remList)) - 1));

endmodule

// File: rtl/multi_xfer_ctrl.sv
module multi_xfer_ctrl
  import multi_xfer_pkg::*;
#(
  parameter int NREGS   = 16,
  localparam int IDXW   = $clog2(NREGS),
  localparam int PC_IDX = NREGS - 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            isLoad,
  input  logic            wrBack,
  input  logic            sBit,
  input  logic            privileged,
  input  logic [IDXW-1:0] baseIdx,
  input  logic            pcInList,
  input  logic            listEmpty,
  input  logic            lastOne,
  input  logic [IDXW-1:0] curReg,
  output dpCtl_t          ctl,
  output logic            busy,
  output logic            done,
  output logic            xferValid,
  output logic            xferUserBank,
  output logic            xferLoad,
  output logic            statusRestore,
  output logic            wbValid,
  output logic [IDXW-1:0] wbIdx,
  output logic            illegalS,
  output logic            illegalBase,
  output logic            wbConflict,
  output logic            bankStall
);

  seqState_t state, stateNext;

  logic accept;
  logic userBankC, restoreC, badBaseC;
  logic loadR, wrBackR, userBankR, restoreR;
  logic illSR, illBaseR, conflictR, stallPendR;
  logic [IDXW-1:0] wbIdxR;

  assign accept    = start && (state == ST_IDLE);
  assign badBaseC  = (baseIdx == IDXW'(PC_IDX));
  assign userBankC = sBit && privileged && !(isLoad && pcInList);
  assign restoreC  = sBit && privileged && isLoad && pcInList;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNext = (badBaseC || listEmpty) ? ST_FIN : ST_XFER;
      ST_XFER:  if (lastOne) stateNext = ST_FIN;
      ST_FIN:   stateNext = stallPendR ? ST_STALL : ST_IDLE;
      ST_STALL: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      loadR      <= 1'b0;
      wrBackR    <= 1'b0;
      userBankR  <= 1'b0;
      restoreR   <= 1'b0;
      illSR      <= 1'b0;
      illBaseR   <= 1'b0;
      conflictR  <= 1'b0;
      stallPendR <= 1'b0;
      wbIdxR     <= '0;
    end else begin
      state <= stateNext;
      if (accept) begin
        loadR      <= isLoad;
        wrBackR    <= wrBack;
        userBankR  <= userBankC;
        restoreR   <= restoreC;
        illSR      <= sBit && !privileged;
        illBaseR   <= badBaseC;
        conflictR  <= wrBack && userBankC && !badBaseC;
        stallPendR <= userBankC && isLoad && !listEmpty && !badBaseC;
        wbIdxR     <= baseIdx;
      end
    end
  end

  assign ctl.load      = accept;
  assign ctl.step      = (state == ST_XFER);

  assign busy          = (state != ST_IDLE);
  assign xferValid     = (state == ST_XFER);
  assign xferUserBank  = xferValid && userBankR;
  assign xferLoad      = xferValid && loadR;
  assign statusRestore = xferValid && restoreR && (curReg == IDXW'(PC_IDX));
  assign done          = (state == ST_FIN);
  assign wbValid       = done && wrBackR && !conflictR && !illBaseR;
  assign wbIdx         = wbIdxR;
  assign illegalS      = done && illSR;
  assign illegalBase   = done && illBaseR;
  assign wbConflict    = done && conflictR;
  assign bankStall     = (state == ST_STALL);

  // R4
  restore_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusRestore |-> (xferValid && xferLoad && !xferUserBank));

  // R7
  conflict_nowb_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbConflict |-> (done && !wbValid));

  // R9
  stall_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    bankStall |-> ($past(done) && busy));

  // R8
  badbase_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalBase |-> ($past(state) == ST_IDLE));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(wbIdx));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/multi_xfer_seq.sv
module multi_xfer_seq
  import multi_xfer_pkg::*;
#(
  parameter int NREGS      = 16,
  parameter int XLEN       = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDXW      = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NREGS-1:0] regList,
  input  logic [IDXW-1:0]  baseIdx,
  input  logic [XLEN-1:0]  baseVal,
  input  logic             isLoad,
  input  logic             addUp,
  input  logic             preIdx,
  input  logic             wrBack,
  input  logic             sBit,
  input  logic             privileged,
  output logic             busy,
  output logic             done,
  output logic             xferValid,
  output logic [XLEN-1:0]  xferAddr,
  output logic [IDXW-1:0]  xferReg,
  output logic             xferUserBank,
  output logic             xferLoad,
  output logic             statusRestore,
  output logic             wbValid,
  output logic [IDXW-1:0]  wbIdx,
  output logic [XLEN-1:0]  wbVal,
  output logic             illegalS,
  output logic             illegalBase,
  output logic             wbConflict,
  output logic             bankStall
);

  dpCtl_t          dpCtl;
  logic            lastOne;
  logic [IDXW-1:0] curReg;

  multi_xfer_ctrl #(.NREGS(NREGS)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .isLoad(isLoad), .wrBack(wrBack),
    .sBit(sBit), .privileged(privileged), .baseIdx(baseIdx),
    .pcInList(regList[NREGS-1]), .listEmpty(regList == '0),
    .lastOne(lastOne), .curReg(curReg), .ctl(dpCtl),
    .busy(busy), .done(done), .xferValid(xferValid), .xferUserBank(xferUserBank),
    .xferLoad(xferLoad), .statusRestore(statusRestore), .wbValid(wbValid),
    .wbIdx(wbIdx), .illegalS(illegalS), .illegalBase(illegalBase),
    .wbConflict(wbConflict), .bankStall(bankStall)
  );

  multi_xfer_dp #(.NREGS(NREGS), .XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .regList(regList), .baseVal(baseVal),
    .addUp(addUp), .preIdx(preIdx), .curReg(curReg), .curAddr(xferAddr),
    .wbVal(wbVal), .lastOne(lastOne)
  );

  assign xferReg = curReg;

endmodule

// File: tb/tb_multi_xfer_seq.sv
module tb_multi_xfer_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] regList = '0;
  logic [3:0]  baseIdx = '0;
  logic [31:0] baseVal = '0;
  logic        isLoad = 1'b0, addUp = 1'b0, preIdx = 1'b0, wrBack = 1'b0;
  logic        sBit = 1'b0, privileged = 1'b0;
  logic        busy, done, xferValid, xferUserBank, xferLoad, statusRestore;
  logic        wbValid, illegalS, illegalBase, wbConflict, bankStall;
  logic [31:0] xferAddr, wbVal;
  logic [3:0]  xferReg, wbIdx;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  multi_xfer_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .regList(regList), .baseIdx(baseIdx),
    .baseVal(baseVal), .isLoad(isLoad), .addUp(addUp), .preIdx(preIdx),
    .wrBack(wrBack), .sBit(sBit), .privileged(privileged), .busy(busy),
    .done(done), .xferValid(xferValid), .xferAddr(xferAddr), .xferReg(xferReg),
    .xferUserBank(xferUserBank), .xferLoad(xferLoad), .statusRestore(statusRestore),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbVal(wbVal), .illegalS(illegalS),
    .illegalBase(illegalBase), .wbConflict(wbConflict), .bankStall(bankStall)
  );

  typedef struct {
    bit          xv;
    logic [31:0] addr;
    int          rg;
    bit          ub;
    bit          ld;
    bit          rs;
    bit          dn;
    bit          wbv;
    logic [31:0] wbv32;
    int          wbi;
    bit          ils;
    bit          ilb;
    bit          cf;
    bit          st;
    bit          bz;
  } exp_t;

  exp_t expQ[$];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareCycle(string tag, exp_t e);
    chk(tag, "busy", 32'(busy), 32'(e.bz));
    chk(tag, "xferValid", 32'(xferValid), 32'(e.xv));
    if (e.xv) begin
      chk(tag, "xferReg", 32'(xferReg), 32'(e.rg));
      chk(tag, "xferAddr", xferAddr, e.addr);
      chk(tag, "xferLoad", 32'(xferLoad), 32'(e.ld));
    end
    chk(tag, "xferUserBank", 32'(xferUserBank), 32'(e.ub));
    chk(tag, "statusRestore", 32'(statusRestore), 32'(e.rs));
    chk(tag, "done", 32'(done), 32'(e.dn));
    chk(tag, "wbValid", 32'(wbValid), 32'(e.wbv));
    if (e.wbv) begin
      chk(tag, "wbVal", wbVal, e.wbv32);
      chk(tag, "wbIdx", 32'(wbIdx), 32'(e.wbi));
    end
    chk(tag, "illegalS", 32'(illegalS), 32'(e.ils));
    chk(tag, "illegalBase", 32'(illegalBase), 32'(e.ilb));
    chk(tag, "wbConflict", 32'(wbConflict), 32'(e.cf));
    chk(tag, "bankStall", 32'(bankStall), 32'(e.st));
  endtask

  // reference model: the expected per-cycle trace for one command
  task automatic buildExp(logic [15:0] lst, int bidx, logic [31:0] base, bit ld,
                          bit up, bit pre, bit wb, bit s, bit priv);
    int n = 0;
    bit badBase = (bidx == 15);
    bit userBank = s && priv && !(ld && lst[15]);
    bit restoreEn = s && priv && ld && lst[15];
    logic [31:0] a;
    exp_t e;
    for (int i = 0; i < 16; i++) if (lst[i]) n++;
    if (up) a = pre ? base + 4 : base;
    else    a = pre ? base - 32'(4 * n) : base - 32'(4 * n) + 4;
    expQ.delete();
    if (!badBase) begin
      for (int i = 0; i < 16; i++) begin
        if (lst[i]) begin
          e = '{default: 0};
          e.bz = 1; e.xv = 1; e.rg = i; e.addr = a; e.ld = ld;
          e.ub = userBank; e.rs = restoreEn && (i == 15);
          expQ.push_back(e);
          a = a + 4;
        end
      end
    end
    e = '{default: 0};
    e.bz = 1; e.dn = 1;
    e.cf = wb && userBank && !badBase;
    e.wbv = wb && !e.cf && !badBase;
    e.wbv32 = up ? base + 32'(4 * n) : base - 32'(4 * n);
    e.wbi = bidx;
    e.ils = s && !priv;
    e.ilb = badBase;
    expQ.push_back(e);
    if (userBank && ld && n > 0 && !badBase) begin
      e = '{default: 0};
      e.bz = 1; e.st = 1;
      expQ.push_back(e);
    end
  endtask

  task automatic runCmd(string tag, logic [15:0] lst, int bidx, logic [31:0] base,
                        bit ld, bit up, bit pre, bit wb, bit s, bit priv, int glitch);
    exp_t idle;
    buildExp(lst, bidx, base, ld, up, pre, wb, s, priv);
    @(negedge clk);
    regList = lst; baseIdx = 4'(bidx); baseVal = base; isLoad = ld; addUp = up;
    preIdx = pre; wrBack = wb; sBit = s; privileged = priv; start = 1'b1;
    for (int k = 0; k < expQ.size(); k++) begin
      @(negedge clk);
      compareCycle(tag, expQ[k]);
      start = (k == glitch);
      if (k == glitch) begin
        regList = ~lst; baseIdx = 4'(bidx + 1); baseVal = base ^ 32'hFFFF_0000;
      end
    end
    @(negedge clk);
    idle = '{default: 0};
    compareCycle({tag, "-idle"}, idle);
    start = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    exp_t idle;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    idle = '{default: 0};
    compareCycle("R11-reset", idle);

    // R2: down/before example, registers 1,5,7 from 0x1000
    runCmd("R2", 16'h00A2, 3, 32'h0000_1000, 0, 0, 1, 1, 0, 1, -1);
    // R1: up/after store with write-back
    runCmd("R1", 16'h8421, 2, 32'h0000_2000, 0, 1, 0, 1, 0, 1, -1);
    // R2: up/before load
    runCmd("R2", 16'h00F0, 4, 32'h0000_0300, 1, 1, 1, 0, 0, 0, -1);
    // R3: down/after store with write-back
    runCmd("R3", 16'h0C03, 6, 32'h0000_4000, 0, 0, 0, 1, 0, 0, -1);
    // R4: privileged load with pc and bank/mode bit
    runCmd("R4", 16'h8003, 13, 32'h0000_0500, 1, 1, 0, 0, 1, 1, -1);
    // R5: privileged store with pc and bank/mode bit -> user bank
    runCmd("R5", 16'h8010, 13, 32'h0000_0800, 0, 0, 1, 0, 1, 1, -1);
    // R9: user-bank load without pc -> stall after done
    runCmd("R9", 16'h0006, 0, 32'h0000_0900, 1, 1, 0, 0, 1, 1, -1);
    // R6: bank/mode bit in user mode
    runCmd("R6", 16'h8001, 1, 32'h0000_0A00, 1, 1, 0, 0, 1, 0, -1);
    // R7: write-back with user-bank store
    runCmd("R7", 16'h0030, 2, 32'h0000_0B00, 0, 1, 0, 1, 1, 1, -1);
    // R8: pc as base
    runCmd("R8", 16'h000F, 15, 32'h0000_0C00, 1, 1, 0, 1, 0, 1, -1);
    // R10: empty mask with write-back
    runCmd("R10", 16'h0000, 5, 32'h0000_1234, 0, 0, 1, 1, 0, 1, -1);
    // R11: stray start in the middle of a command
    runCmd("R11", 16'h00FF, 7, 32'h0000_2400, 1, 0, 0, 1, 0, 1, 2);
    // R1: full mask, ascending order
    runCmd("R1", 16'hFFFF, 8, 32'h0001_0000, 1, 1, 1, 0, 0, 1, -1);
    // R10: empty mask with user-bank load: no stall
    runCmd("R10", 16'h0000, 3, 32'h0000_0040, 1, 1, 0, 0, 1, 1, -1);

    finish();
  end

endmodule